// File: doc/BRIEF.md
# Flash programming sequencer

This block programs a run of consecutive words into a NOR-type flash device from the host side. A single start pulse supplies a base address and a word count. For each word, the block pulls the data from a valid/ready source. It then drives the three-write unlock preamble and the data write onto a plain parallel bus. After that it polls the device's status bit until the device's internal programming settles. A full read-back confirms the word before the block moves on to the next address.

The bus has three strobes: chip-enable, write-enable and output-enable. A write lasts one clock. A read presents its address in one clock and receives data in the next. Each word has a budget of failed reads. If a device never settles, the block raises an error flag and stops. It keeps the address that failed until the next start.

Top module: `flash_prog_seq`

## Requirements
- R1: For each word, the block performs four back-to-back one-clock writes with chip-enable and write-enable high and output-enable low. In order they are: 0x00AA to address 0x555, 0x0055 to 0x2AA, 0x00A0 to 0x555, then the word's data to its target address.
- R2: `src_ready_o` is high only while the block waits for the next word, and the bus is idle during that time. A word is taken on a clock where valid and ready are both high. With valid low, the block waits with no timeout.
- R3: A status poll is a one-clock read of the target address, followed by one clock in which the block checks the returned data. If bit 7 of the returned data differs from bit 7 of the intended data, the block polls again.
- R4: When bit 7 matches, the block reads the target again and compares the full word. A mismatch sends it back to polling, and the mismatch counts as a failed read.
- R5: After a word verifies, the block spends one idle cycle and then handles the next word at address+1. After the last word, `done_o` pulses for exactly one cycle and `busy_o` is low in that same cycle.
- R6: A word that collects POLL_LIMIT failed reads ends the run. In the following cycle `error_o` goes high, `fail_addr_o` holds the word's address and `busy_o` falls. The error flag stays set until the next start.
- R7: A start pulse while busy has no effect on the bus sequence, on the addresses or on the number of words.
- R8: A start with a count of zero gives a `done_o` pulse in the next cycle and no bus cycle.
- R9: After reset, busy, done, error and all three bus strobes are low.
- R10: Write-enable and output-enable are never high together, and neither is ever high without chip-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled only when idle |
| base_addr_i | input | ADDR_W | First target word address |
| count_i | input | CNT_W | Number of words to program |
| src_valid_i | input | 1 | Source word available |
| src_data_i | input | DATA_W | Source word |
| src_ready_o | output | 1 | Block accepts a source word |
| bus_addr_o | output | ADDR_W | Flash word address |
| bus_wdata_o | output | DATA_W | Flash write data |
| bus_rdata_i | input | DATA_W | Flash read data, valid one clock after the read |
| bus_ce_o | output | 1 | Chip-enable |
| bus_we_o | output | 1 | Write-enable |
| bus_oe_o | output | 1 | Output-enable |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Poll budget exhausted, sticky until start |
| fail_addr_o | output | ADDR_W | Address of the word that failed |

## Verification
Some pairs of events can fall in the same cycle, and these are the ones that need attention.

The first pair is a verify miss and the end of the poll budget. The bench provokes it with a device that settles but returns one corrupted read-back. A second case uses a device that stays busy for exactly one read fewer than the budget allows. In both cases the word must still complete, and the block must not raise an error.

The second pair is the done pulse, or a stray start, arriving in the same cycle as the run's own state changes. The bench pulses start in the middle of a run and starts a zero-length run. A behavioural model predicts every bus cycle, and the outputs are compared against it on every clock.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_CMD0, ST_CMD1, ST_CMD2, ST_PROG,
    ST_PRD, ST_PCHK, ST_VRD, ST_VCHK, ST_NEXT
  } seq_state_e;

  localparam logic [11:0] KEY_ADDR_A = 12'h555;
  localparam logic [11:0] KEY_ADDR_B = 12'h2AA;
  localparam logic [7:0]  KEY_DATA_A = 8'hAA;
  localparam logic [7:0]  KEY_DATA_B = 8'h55;
  localparam logic [7:0]  KEY_PROG   = 8'hA0;
  localparam int unsigned STATUS_BIT = 7;
endpackage

// File: rtl/flash_cmd_step.sv
module flash_cmd_step
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic [1:0]        step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    unique case (step_i)
      2'd0:    begin addr_o = ADDR_W'(KEY_ADDR_A); data_o = DATA_W'(KEY_DATA_A); end
      2'd1:    begin addr_o = ADDR_W'(KEY_ADDR_B); data_o = DATA_W'(KEY_DATA_B); end
      default: begin addr_o = ADDR_W'(KEY_ADDR_A); data_o = DATA_W'(KEY_PROG);   end
    endcase
  end
endmodule

// File: rtl/flash_poll_ctr.sv
module flash_poll_ctr #(
  parameter int unsigned LIMIT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST_V);
endmodule

// File: rtl/flash_addr_track.sv
module flash_addr_track #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      rem_q  <= count_i;
    end else if (adv_i) begin
      addr_q <= addr_q + 1'b1;
      rem_q  <= rem_q - 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (rem_q == CNT_W'(1));
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned POLL_LIMIT = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_ready_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_ce_o,
  output logic              bus_we_o,
  output logic              bus_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic [ADDR_W-1:0] fail_addr_o
);
  seq_state_e        state_q;
  logic [DATA_W-1:0] word_q;
  logic              done_q, err_q;
  logic [ADDR_W-1:0] fail_q;

  logic [1:0]        step;
  logic [ADDR_W-1:0] key_addr, cur_addr;
  logic [DATA_W-1:0] key_data;
  logic              load, adv, last_word;
  logic              take, poll_last, miss, poll_ok, vfy_ok;

  assign take    = (state_q == ST_FETCH) && src_valid_i;
  assign load    = (state_q == ST_IDLE) && start_i && (count_i != '0);
  assign poll_ok = bus_rdata_i[STATUS_BIT] == word_q[STATUS_BIT];
  assign vfy_ok  = bus_rdata_i == word_q;
  assign miss    = ((state_q == ST_PCHK) && !poll_ok) ||
                   ((state_q == ST_VCHK) && !vfy_ok);
  assign adv     = (state_q == ST_NEXT) && !last_word;

  always_comb begin
    unique case (state_q)
      ST_CMD1: step = 2'd1;
      ST_CMD2: step = 2'd2;
      default: step = 2'd0;
    endcase
  end

  flash_cmd_step #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .step_i(step), .addr_o(key_addr), .data_o(key_data)
  );

  flash_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(take),
    .inc_i(miss && !poll_last), .last_o(poll_last)
  );

  flash_addr_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .base_i(base_addr_i),
    .count_i(count_i), .adv_i(adv), .addr_o(cur_addr), .last_o(last_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      fail_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          err_q <= 1'b0;
          if (count_i == '0) done_q  <= 1'b1;
          else               state_q <= ST_FETCH;
        end
        ST_FETCH: if (src_valid_i) begin
          word_q  <= src_data_i;
          state_q <= ST_CMD0;
        end
        ST_CMD0: state_q <= ST_CMD1;
        ST_CMD1: state_q <= ST_CMD2;
        ST_CMD2: state_q <= ST_PROG;
        ST_PROG: state_q <= ST_PRD;
        ST_PRD:  state_q <= ST_PCHK;
        ST_VRD:  state_q <= ST_VCHK;
        ST_PCHK, ST_VCHK: begin
          if (!miss) begin
            state_q <= (state_q == ST_PCHK) ? ST_VRD : ST_NEXT;
          end else if (poll_last) begin
            err_q   <= 1'b1;
            fail_q  <= cur_addr;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_PRD;
          end
        end
        ST_NEXT: begin
          if (last_word) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_ce_o    = 1'b0;
    bus_we_o    = 1'b0;
    bus_oe_o    = 1'b0;
    bus_addr_o  = cur_addr;
    bus_wdata_o = '0;
    unique case (state_q)
      ST_CMD0, ST_CMD1, ST_CMD2: begin
        bus_ce_o    = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = key_addr;
        bus_wdata_o = key_data;
      end
      ST_PROG: begin
        bus_ce_o    = 1'b1;
        bus_we_o    = 1'b1;
        bus_wdata_o = word_q;
      end
      ST_PRD, ST_VRD: begin
        bus_ce_o = 1'b1;
        bus_oe_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign src_ready_o = (state_q == ST_FETCH);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign error_o     = err_q;
  assign fail_addr_o = fail_q;
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              src_ready_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_ce_o,
  input logic              bus_we_o,
  input logic              bus_oe_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              error_o
);
  AST_WE_OE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_o && bus_oe_o)) else $error("we/oe overlap"); // R10
  AST_STROBE_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o || bus_oe_o) |-> bus_ce_o) else $error("strobe without ce"); // R10
  AST_PREAMBLE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && !$past(bus_we_o)) |-> (bus_addr_o == ADDR_W'(12'h555) &&
    bus_wdata_o == DATA_W'(8'hAA))) else $error("bad first unlock write"); // R1
  AST_READY_BUS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> (!bus_ce_o && busy_o)) else $error("bus active while fetching"); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o) else $error("done while busy"); // R5
  AST_ERROR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (error_o && !start_i) |=> error_o) else $error("error dropped"); // R6
  AST_ERROR_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !busy_o) else $error("error while busy"); // R6
  AST_ZERO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && count_i == '0) |=> (done_o && !busy_o)) else $error("zero count"); // R8
endmodule

bind flash_prog_seq flash_prog_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .count_i(count_i),
  .src_ready_o(src_ready_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
  .bus_ce_o(bus_ce_o), .bus_we_o(bus_we_o), .bus_oe_o(bus_oe_o),
  .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
);

// File: tb/sim_flash_prog_seq.sv
`timescale 1ns/1ps
module sim_flash_prog_seq;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int P  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, src_valid = 1'b0;
  logic [AW-1:0] base = '0;
  logic [CW-1:0] count = '0;
  logic [DW-1:0] src_data = '0, rdata = '0;
  logic src_ready, ce, we, oe, busy, done, err;
  logic [AW-1:0] baddr, fail_addr;
  logic [DW-1:0] wdata;

  always #2.5 clk = ~clk;

  flash_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .POLL_LIMIT(P)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base), .count_i(count),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_ready_o(src_ready),
    .bus_addr_o(baddr), .bus_wdata_o(wdata), .bus_rdata_i(rdata),
    .bus_ce_o(ce), .bus_we_o(we), .bus_oe_o(oe), .busy_o(busy), .done_o(done),
    .error_o(err), .fail_addr_o(fail_addr)
  );

  int total = 0, bad = 0;
  logic [DW-1:0] words [16];
  int lat_a [16];
  int glt_a [16];
  logic [AW-1:0] cur_base = '0;

  function automatic logic [DW-1:0] resp(int w, int j, logic [DW-1:0] d);
    if (j < lat_a[w]) return d ^ 16'h0080;
    if (j == glt_a[w]) return d ^ 16'h0001;
    return d;
  endfunction

  // device model: registered read data, status busy for lat_a reads
  bit dev_arm = 0;
  int dev_cur = 0, dev_j = 0;
  logic [DW-1:0] dev_pend = '0;
  always @(posedge clk) begin
    if (ce && we) begin
      if (dev_arm) begin
        dev_arm  <= 0;
        dev_pend <= wdata;
        dev_j    <= 0;
        dev_cur  <= int'(baddr - cur_base);
      end else if (baddr == 20'h555 && wdata == 16'h00A0) dev_arm <= 1;
    end
    if (ce && oe) begin
      rdata <= resp(dev_cur, dev_j, dev_pend);
      dev_j <= dev_j + 1;
    end
  end

  typedef struct {
    bit busy, rdy, ce, we, oe, done, err;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    string tag;
  } exp_t;
  exp_t q[$];

  task automatic push(bit b, bit r, bit c, bit w, bit o, bit d, bit e,
                      logic [AW-1:0] a, logic [DW-1:0] wd, string t);
    exp_t x;
    x.busy = b; x.rdy = r; x.ce = c; x.we = w; x.oe = o; x.done = d; x.err = e;
    x.addr = a; x.wd = wd; x.tag = t;
    q.push_back(x);
  endtask

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic gen(logic [AW-1:0] b, int cnt, int stall);
    for (int w = 0; w < cnt; w++) begin
      logic [AW-1:0] a = b + AW'(w);
      logic [DW-1:0] d = words[w];
      int miss = 0, j = 0;
      if (w == 0) for (int s = 0; s < stall; s++) push(1,1,0,0,0,0,0,'0,'0,"R2");
      push(1,1,0,0,0,0,0,'0,'0,"R2");
      push(1,0,1,1,0,0,0,20'h555,16'h00AA,"R1");
      push(1,0,1,1,0,0,0,20'h2AA,16'h0055,"R1");
      push(1,0,1,1,0,0,0,20'h555,16'h00A0,"R1");
      push(1,0,1,1,0,0,0,a,d,"R1");
      forever begin
        bit hit = 0;
        logic [DW-1:0] v;
        push(1,0,1,0,1,0,0,a,'0,"R3");
        push(1,0,0,0,0,0,0,'0,'0,"R3");
        v = resp(w, j, d); j++;
        if (v[7] == d[7]) begin
          push(1,0,1,0,1,0,0,a,'0,"R4");
          push(1,0,0,0,0,0,0,'0,'0,"R4");
          v = resp(w, j, d); j++;
          hit = (v == d);
        end
        if (hit) begin
          push(1,0,0,0,0,0,0,'0,'0,"R5");
          break;
        end
        if (miss == P - 1) begin
          push(0,0,0,0,0,0,1,a,'0,"R6");
          push(0,0,0,0,0,0,1,a,'0,"R6");
          return;
        end
        miss++;
      end
    end
    push(0,0,0,0,0,1,0,'0,'0,"R5");
    push(0,0,0,0,0,0,0,'0,'0,"R5");
  endtask

  task automatic run(logic [AW-1:0] b, int cnt, int stall, int mid);
    int cyc = 0, stall_left = stall, idx = 0;
    bit prev_acc = 0;
    cur_base = b;
    q.delete();
    if (cnt == 0) begin
      push(0,0,0,0,0,1,0,'0,'0,"R8");
      push(0,0,0,0,0,0,0,'0,'0,"R8");
    end else gen(b, cnt, stall);
    @(negedge clk);
    base = b; count = CW'(cnt); start = 1; src_valid = 1; src_data = words[0];
    while (q.size() > 0) begin
      exp_t e;
      bit ok;
      @(negedge clk);
      start = (cyc == mid);
      count = (cyc == mid) ? CW'(7) : CW'(cnt);
      base  = (cyc == mid) ? 20'h00F00 : b;
      e = q.pop_front();
      ok = busy == e.busy && src_ready == e.rdy && ce == e.ce && we == e.we &&
           oe == e.oe && done == e.done && err == e.err &&
           (!e.ce || baddr == e.addr) && (!e.we || wdata == e.wd) &&
           (!e.err || fail_addr == e.addr);
      check(ok, e.tag, "cycle",
            {busy, src_ready, ce, we, oe, done, err, 1'b0, wdata, 4'h0, baddr},
            {e.busy, e.rdy, e.ce, e.we, e.oe, e.done, e.err, 1'b0, e.wd, 4'h0, e.addr});
      if (prev_acc) idx++;
      if (src_ready && stall_left > 0) begin src_valid = 0; stall_left--; end
      else src_valid = 1;
      src_data = words[idx % 16];
      prev_acc = src_valid && src_ready;
      cyc++;
    end
    start = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      words[i] = DW'(16'h1357 * (i + 3)) ^ ((i % 2) ? 16'h0080 : 16'h0000);
      lat_a[i] = 0;
      glt_a[i] = -1;
    end
    #1;
    check(!busy && !done && !err && !ce && !we && !oe, "R9", "reset outputs",
          {58'd0, busy, done, err, ce, we, oe}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !err && !ce && !src_ready, "R9", "after reset",
          {59'd0, busy, done, err, ce, src_ready}, 64'd0);

    // R1 R3 R5 R7: three words, latencies 0, P-1 (one short of budget), 2; stray start mid-run
    lat_a[0] = 0; lat_a[1] = P - 1; lat_a[2] = 2;
    run(20'h00100, 3, 0, 9);
    repeat (4) begin
      @(negedge clk);
      check(!busy && !ce && !done, "R7", "quiet after run", {61'd0, busy, ce, done}, 64'd0);
    end

    // R4: corrupted first read-back, R2: source stalls three cycles
    for (int i = 0; i < 16; i++) begin lat_a[i] = 0; glt_a[i] = -1; end
    glt_a[0] = 1; lat_a[1] = 1;
    run(20'h3FFFE, 2, 3, -1);

    // R8: zero count
    run(20'h00040, 0, 0, -1);

    // R6: device never settles
    for (int i = 0; i < 16; i++) begin lat_a[i] = 0; glt_a[i] = -1; end
    lat_a[1] = 1000;
    run(20'h00200, 3, 0, -1);
    repeat (3) begin
      @(negedge clk);
      check(err && !busy && fail_addr == 20'h00201, "R6", "error held",
            {43'd0, err, busy, fail_addr}, {43'd0, 1'b1, 1'b0, 20'h00201});
    end

    // R6: new start clears the error and programs normally
    lat_a[1] = 0;
    run(20'h00500, 1, 0, -1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt <= wd_cnt + 1;
    if (wd_cnt > 20000) begin
      total++; bad++;
      $display("FAIL watchdog R5 act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule